// File: doc/BRIEF.md
# ZUC Keystream Word Generator

This block turns a 128-bit secret key and a 128-bit initialization vector into a stream of 32-bit ZUC keystream words. A one-cycle `start` pulse captures the key and IV into a sixteen-cell shift register of 31-bit cells. The register then runs a fixed number of mixing rounds, in which the nonlinear function's output is fed back into the register. After one further step whose result is thrown away, the block offers keystream words on a valid/ready output, one word per accepted handshake.

Each step rearranges eight register cells into four 32-bit words. Three of them drive a nonlinear function that keeps two 32-bit state registers. That function uses two linear diffusion transforms and two byte substitution boxes. The boxes are computed as combinational logic, so a whole step completes in one clock cycle. The keystream word is the function output XORed with the fourth rearranged word. Register feedback is arithmetic modulo 2^31-1.

The output interface follows these back-pressure rules. `ks_valid` stays high from the first word until the next `start`. While `ks_ready` is low, the generator stalls and `ks_word` holds its value. A word is consumed on every clock edge where `ks_valid` and `ks_ready` are both high. `busy` is a plain status level. `start` may be raised at any time and always wins over a handshake in the same cycle.

Top module: `zuc_keystream`

## Requirements
- R1: After reset, `busy` and `ks_valid` are both low.
- R2: On the clock edge that samples `start` high, the key and IV are captured. `busy` is then high for exactly 33 cycles: 32 mixing rounds plus one discarded step. After that, `ks_valid` rises with the first word.
- R3: Key byte i is `key[127-8i -: 8]` and IV byte i is `iv[127-8i -: 8]`. Byte i of both goes into cell i. With an all-zero key and IV, the first two words are 32'h27BEDE74 and 32'h018082DA.
- R4: With an all-ones key and IV, the first two words are 32'h0657CFA0 and 32'h7096398B.
- R5: While `ks_valid` is high and `ks_ready` is low, `ks_valid` stays high and `ks_word` does not change.
- R6: The sequence of words delivered does not depend on how many stall cycles come before each handshake.
- R7: A `start` during the mixing phase, or in the same cycle as an output handshake, discards the current run. No word is counted, `busy` is high and `ks_valid` is low on the next cycle, and the stream restarts from the new key and IV.
- R8: `busy` and `ks_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse: capture key and IV and begin a new stream |
| key | input | 128 | Secret key, byte 0 in the top eight bits |
| iv | input | 128 | Initialization vector, byte 0 in the top eight bits |
| ks_ready | input | 1 | Consumer accepts the offered word |
| ks_valid | output | 1 | A keystream word is offered |
| ks_word | output | 32 | Current keystream word |
| busy | output | 1 | Mixing rounds or the discarded step in progress |

## Verification
Two events can fall in the same cycle: a restart request and a consumed keystream word. The bench creates this overlap by raising `start` and `ks_ready` together while a word is on offer. It then checks three things: the next cycle shows `busy` high and `ks_valid` low, the busy phase lasts its full length, and the first word afterwards is the fresh first word for the new key rather than the second word of the old stream. A restart during the mixing phase is judged the same way. Stall tolerance is checked by sweeping the number of stall cycles before each handshake and comparing the words with an unstalled run.

// File: rtl/zuc_pkg.sv
package zuc_pkg;

  localparam int CELL_W  = 31;
  localparam int WORD_W  = 32;
  localparam int N_CELLS = 16;

  typedef logic [CELL_W-1:0] cell_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {PH_IDLE, PH_MIX, PH_SKIP, PH_RUN} phase_e;

  // nibble tables of the first substitution box, entry k at [4k +: 4]
  localparam logic [63:0] NIB_A = 64'h9357C040A2FFE0F9;
  localparam logic [63:0] NIB_B = 64'h293FAE1B4C0756D8;
  localparam logic [63:0] NIB_C = 64'hDC905D33FAD06A62;
  // columns of the affine matrix of the second box, column k at [8k +: 8]
  localparam logic [63:0] AFF_COLS  = 64'h77BBDDEECB6D3E97;
  localparam logic [7:0]  AFF_CONST = 8'h55;

  function automatic logic [14:0] load_const(input int idx);
    case (idx)
      0: return 15'h44D7;   1: return 15'h26BC;   2: return 15'h626B;   3: return 15'h135E;
      4: return 15'h5789;   5: return 15'h35E2;   6: return 15'h7135;   7: return 15'h09AF;
      8: return 15'h4D78;   9: return 15'h2F13;  10: return 15'h6BC4;  11: return 15'h1AF1;
      12: return 15'h5E26; 13: return 15'h3C4D;  14: return 15'h789A;  default: return 15'h47AC;
    endcase
  endfunction

  // multiply by 2^k modulo 2^31-1
  function automatic cell_t rot31(input cell_t a, input int k);
    return (a << k) | (a >> (CELL_W - k));
  endfunction

  // addition modulo 2^31-1 with end-around carry
  function automatic cell_t add_mod(input cell_t a, input cell_t b);
    logic [CELL_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[CELL_W-1:0] + {{(CELL_W-1){1'b0}}, s[CELL_W]};
  endfunction

  function automatic word_t rotl32(input word_t x, input int k);
    return (x << k) | (x >> (WORD_W - k));
  endfunction

  function automatic word_t diffuse_a(input word_t x);
    return x ^ rotl32(x, 2) ^ rotl32(x, 10) ^ rotl32(x, 18) ^ rotl32(x, 24);
  endfunction

  function automatic word_t diffuse_b(input word_t x);
    return x ^ rotl32(x, 8) ^ rotl32(x, 14) ^ rotl32(x, 22) ^ rotl32(x, 30);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = '0;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[7] ? ((x << 1) ^ 8'h8B) : (x << 1);
    end
    return acc;
  endfunction

  // field inverse as a^254, zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    logic [7:0] base;
    r    = 8'h01;
    base = a;
    for (int i = 0; i < 8; i++) begin
      if (i != 0) r = gf_mul(r, base);
      base = gf_mul(base, base);
    end
    return r;
  endfunction

  function automatic logic [7:0] sub_a(input logic [7:0] x);
    logic [3:0] t1, t2, t3;
    logic [7:0] y;
    t1 = x[7:4] ^ NIB_A[{x[3:0], 2'b00} +: 4];
    t2 = x[3:0] ^ NIB_B[{t1, 2'b00} +: 4];
    t3 = t1 ^ NIB_C[{t2, 2'b00} +: 4];
    y  = {t3, t2};
    return {y[2:0], y[7:3]};
  endfunction

  function automatic logic [7:0] sub_b(input logic [7:0] x);
    logic [7:0] inv;
    logic [7:0] y;
    inv = gf_inv(x);
    y   = AFF_CONST;
    for (int k = 0; k < 8; k++)
      if (inv[k]) y = y ^ AFF_COLS[8*k +: 8];
    return y;
  endfunction

  function automatic word_t sub_word(input word_t w);
    return {sub_a(w[31:24]), sub_b(w[23:16]), sub_a(w[15:8]), sub_b(w[7:0])};
  endfunction

endpackage

// File: rtl/zuc_lfsr.sv
module zuc_lfsr
  import zuc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         mix_mode,
  input  logic [127:0] key,
  input  logic [127:0] iv,
  input  cell_t        fold_in,
  output word_t        x0,
  output word_t        x1,
  output word_t        x2,
  output word_t        x3
);

  cell_t cell_q [N_CELLS];
  cell_t lin_fb;
  cell_t new_cell;

  always_comb begin
    lin_fb   = add_mod(cell_q[0], rot31(cell_q[0], 8));
    lin_fb   = add_mod(lin_fb, rot31(cell_q[4], 20));
    lin_fb   = add_mod(lin_fb, rot31(cell_q[10], 21));
    lin_fb   = add_mod(lin_fb, rot31(cell_q[13], 17));
    lin_fb   = add_mod(lin_fb, rot31(cell_q[15], 15));
    new_cell = mix_mode ? add_mod(lin_fb, fold_in) : lin_fb;
    if (new_cell == '0) new_cell = '1;
  end

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    cell_t seed;
    cell_t shift_src;
    assign seed = {key[127-8*i -: 8], load_const(i), iv[127-8*i -: 8]};
    if (i == N_CELLS - 1) begin : g_top
      assign shift_src = new_cell;
    end else begin : g_mid
      assign shift_src = cell_q[i+1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)     cell_q[i] <= '0;
      else if (load)  cell_q[i] <= seed;
      else if (step)  cell_q[i] <= shift_src;
    end
  end

  assign x0 = {cell_q[15][30:15], cell_q[14][15:0]};
  assign x1 = {cell_q[11][15:0],  cell_q[9][30:15]};
  assign x2 = {cell_q[7][15:0],   cell_q[5][30:15]};
  assign x3 = {cell_q[2][15:0],   cell_q[0][30:15]};

endmodule

// File: rtl/zuc_nonlin.sv
module zuc_nonlin
  import zuc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  step,
  input  word_t x0,
  input  word_t x1,
  input  word_t x2,
  output word_t f_out
);

  word_t mem_a, mem_b;
  word_t sum_w, mix_w;
  word_t mem_a_nx, mem_b_nx;

  always_comb begin
    sum_w    = mem_a + x1;
    mix_w    = mem_b ^ x2;
    mem_a_nx = sub_word(diffuse_a({sum_w[15:0], mix_w[31:16]}));
    mem_b_nx = sub_word(diffuse_b({mix_w[15:0], sum_w[31:16]}));
  end

  assign f_out = (x0 ^ mem_a) + mem_b;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      mem_a <= '0;
      mem_b <= '0;
    end else if (step) begin
      mem_a <= mem_a_nx;
      mem_b <= mem_b_nx;
    end
  end

endmodule

// File: rtl/zuc_ctrl.sv
module zuc_ctrl
  import zuc_pkg::*;
#(
  parameter int MIX_ROUNDS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic out_ready,
  output logic load,
  output logic step,
  output logic mix_mode,
  output logic busy,
  output logic out_valid
);

  localparam int CNT_W = (MIX_ROUNDS > 1) ? $clog2(MIX_ROUNDS) : 1;
  localparam logic [CNT_W-1:0] LAST_ROUND = CNT_W'(MIX_ROUNDS - 1);

  phase_e           phase;
  logic [CNT_W-1:0] round_q;

  assign load      = start;
  assign mix_mode  = (phase == PH_MIX);
  assign busy      = (phase == PH_MIX) || (phase == PH_SKIP);
  assign out_valid = (phase == PH_RUN);
  assign step      = !start && (busy || (out_valid && out_ready));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      round_q <= '0;
    end else if (start) begin
      phase   <= PH_MIX;
      round_q <= '0;
    end else begin
      case (phase)
        PH_MIX: begin
          round_q <= round_q + 1'b1;
          if (round_q == LAST_ROUND) phase <= PH_SKIP;
        end
        PH_SKIP: phase <= PH_RUN;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/zuc_keystream.sv
module zuc_keystream
  import zuc_pkg::*;
#(
  parameter int MIX_ROUNDS = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] key,
  input  logic [127:0] iv,
  input  logic         ks_ready,
  output logic         ks_valid,
  output logic [31:0]  ks_word,
  output logic         busy
);

  logic  load, step, mix_mode;
  word_t x0, x1, x2, x3;
  word_t f_out;

  zuc_ctrl #(.MIX_ROUNDS(MIX_ROUNDS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .out_ready (ks_ready),
    .load      (load),
    .step      (step),
    .mix_mode  (mix_mode),
    .busy      (busy),
    .out_valid (ks_valid)
  );

  zuc_lfsr u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step     (step),
    .mix_mode (mix_mode),
    .key      (key),
    .iv       (iv),
    .fold_in  (f_out[31:1]),
    .x0       (x0),
    .x1       (x1),
    .x2       (x2),
    .x3       (x3)
  );

  zuc_nonlin u_nonlin (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load),
    .step  (step),
    .x0    (x0),
    .x1    (x1),
    .x2    (x2),
    .f_out (f_out)
  );

  assign ks_word = f_out ^ x3;

endmodule

// File: rtl/zuc_keystream_chk.sv
module zuc_keystream_chk #(
  parameter int MIX_ROUNDS = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        ks_ready,
  input logic        ks_valid,
  input logic [31:0] ks_word,
  input logic        busy
);

  logic [15:0] busy_len;

  always_ff @(posedge clk) begin
    if (!rst_n)      busy_len <= '0;
    else if (start)  busy_len <= '0;
    else if (busy)   busy_len <= busy_len + 16'd1;
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ks_valid));

  p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !ks_valid));

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy) && !$past(start)) |-> (busy_len == 16'(MIX_ROUNDS + 1)));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !ks_ready && !start) |=> (ks_valid && $stable(ks_word)));

  p_run_persists_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ks_valid && !start) |=> ks_valid);

endmodule

bind zuc_keystream zuc_keystream_chk #(.MIX_ROUNDS(MIX_ROUNDS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .ks_ready (ks_ready),
  .ks_valid (ks_valid),
  .ks_word  (ks_word),
  .busy     (busy)
);

// File: tb/zuc_keystream_tb.sv
module zuc_keystream_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [127:0] key;
  logic [127:0] iv;
  logic         ks_ready;
  logic         ks_valid;
  logic [31:0]  ks_word;
  logic         busy;

  int checks = 0;
  int errors = 0;
  int excl_bad = 0;
  bit finished = 0;

  localparam int EXP_BUSY = 33;

  always #5 clk = ~clk;

  zuc_keystream u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .key      (key),
    .iv       (iv),
    .ks_ready (ks_ready),
    .ks_valid (ks_valid),
    .ks_word  (ks_word),
    .busy     (busy)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // R8 monitor, sampled away from the active edge
  always @(negedge clk) if (rst_n && busy && ks_valid) excl_bad++;

  task automatic count_busy(output int blen);
    blen = 0;
    while (busy && blen < 1000) begin
      blen++;
      @(negedge clk);
    end
  endtask

  task automatic launch(input logic [127:0] k, input logic [127:0] v, output int blen);
    @(negedge clk);
    start = 1'b1; key = k; iv = v;
    @(negedge clk);
    start = 1'b0;
    count_busy(blen);
  endtask

  task automatic get_word(input int stall, output logic [31:0] w);
    int guard = 0;
    while (!ks_valid && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    w = ks_word;
    for (int s = 0; s < stall; s++) begin
      ks_ready = 1'b0;
      @(negedge clk);
      check(ks_valid && ks_word == w, "R5 hold under stall", ks_word, w);
    end
    ks_ready = 1'b1;
    @(negedge clk);
    ks_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] w;
    logic [31:0] ref_words [6];
    int blen;
    rst_n = 1'b0; start = 1'b0; ks_ready = 1'b0; key = '0; iv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy, "R1 busy after reset", {31'd0, busy}, 32'd0);
    check(!ks_valid, "R1 valid after reset", {31'd0, ks_valid}, 32'd0);

    // all-zero vector
    launch('0, '0, blen);
    check(blen == EXP_BUSY, "R2 busy length", blen, EXP_BUSY);
    check(ks_valid, "R2 valid after busy", {31'd0, ks_valid}, 32'd1);
    for (int i = 0; i < 6; i++) begin
      get_word(0, w);
      ref_words[i] = w;
    end
    check(ref_words[0] == 32'h27BEDE74, "R3 zero key word 1", ref_words[0], 32'h27BEDE74);
    check(ref_words[1] == 32'h018082DA, "R3 zero key word 2", ref_words[1], 32'h018082DA);

    // all-ones vector
    launch('1, '1, blen);
    check(blen == EXP_BUSY, "R2 busy length ones", blen, EXP_BUSY);
    get_word(0, w);
    check(w == 32'h0657CFA0, "R4 ones word 1", w, 32'h0657CFA0);
    get_word(0, w);
    check(w == 32'h7096398B, "R4 ones word 2", w, 32'h7096398B);

    // sweep of stall patterns against the unstalled stream
    for (int pat = 1; pat < 4; pat++) begin
      launch('0, '0, blen);
      for (int i = 0; i < 6; i++) begin
        get_word((i * pat) % 4, w);
        check(w == ref_words[i], "R6 stalled stream", w, ref_words[i]);
      end
    end

    // restart in the middle of the mixing phase
    @(negedge clk);
    start = 1'b1; key = '0; iv = '0;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    launch('1, '1, blen);
    check(blen == EXP_BUSY, "R7 busy length after restart", blen, EXP_BUSY);
    get_word(0, w);
    check(w == 32'h0657CFA0, "R7 first word after restart", w, 32'h0657CFA0);

    // restart in the same cycle as a handshake
    check(ks_valid, "R7 valid before collision", {31'd0, ks_valid}, 32'd1);
    ks_ready = 1'b1; start = 1'b1; key = '0; iv = '0;
    @(negedge clk);
    ks_ready = 1'b0; start = 1'b0;
    check(busy && !ks_valid, "R7 busy after collision", {30'd0, busy, ks_valid}, 32'd2);
    count_busy(blen);
    check(blen == EXP_BUSY, "R7 busy length after collision", blen, EXP_BUSY);
    get_word(2, w);
    check(w == 32'h27BEDE74, "R7 fresh word after collision", w, 32'h27BEDE74);

    check(excl_bad == 0, "R8 busy and valid exclusive", excl_bad, 32'd0);
    finish_run();
  end

endmodule